// File: doc/BRIEF.md
# ADC Conversion Cycle Sequencer

This block times one complete sample-and-convert cycle for a successive-approximation analog-to-digital converter. A rising edge on the `convert` input starts the cycle. The block derives a slower conversion clock from its input clock with a programmable power-of-two divider. It then steps through three phases on a fixed schedule of 48 divided periods: 8 periods of offset cancellation, 28 periods of input tracking and 12 periods of bit decisions. While a cycle runs, `busy` stays high.

During the decision phase the block tests one bit per divided period, starting at the most significant bit. It raises a one-hot trial strobe and shows the candidate code on `dac_code`. It then keeps or clears that bit according to the comparator input. At the end of the cycle the result is converted from offset binary to two's complement and registered. A one-clock `data_valid` pulse marks the new result.

The analog parts are outside this block: the comparator, the capacitor array and the amplifier. The sequencer only drives enables and codes to them and reads back one decision bit.

Top module: `sar_conv_seq`

## Requirements
- R1: When idle, a 0-to-1 transition on `convert` starts a cycle, and `busy` is high in the clock that follows the edge that sampled the transition.
- R2: `busy` stays high for exactly 48 × D input clocks, where D is the divide factor.
- R3: `div_sel` codes 0, 1, 2 and 3 select D = 1, 2, 4 and 8. The code is captured when a cycle starts, and changes to it during a cycle have no effect on that cycle.
- R4: `az_en` is high for divided periods 0 to 7, `acq_en` for periods 8 to 35 and `conv_en` for periods 36 to 47. Exactly one of them is high while busy, and none is high while idle.
- R5: `sample_stb` is a single input-clock pulse at the start of divided period 36, which is 36 × D clocks after `busy` rises.
- R6: In conversion period j (0..11), `trial` is one-hot with bit 11−j set. `trial` is zero outside the conversion phase. `dac_code` equals the bits already decided OR `trial`, with undecided bits at zero.
- R7: A `comp_in` of 1 at the end of a conversion period keeps the trial bit, and 0 clears it. The final `result` is the decided offset-binary code with bit 11 inverted (two's complement).
- R8: A rising edge on `convert` while `busy` is high is ignored. Holding `convert` high after a cycle ends does not start another cycle.
- R9: `data_valid` is high for exactly one input clock, in the clock right after `busy` falls. `result` keeps its value until the next cycle completes.
- R10: During reset, `busy`, all phase enables, `sample_stb`, `trial`, `result` and `data_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| convert | input | 1 | Start request; a rising edge starts a cycle |
| div_sel | input | 2 | Conversion clock divide code |
| comp_in | input | 1 | Comparator decision: 1 = input at or above `dac_code` |
| busy | output | 1 | High while a cycle runs |
| az_en | output | 1 | Offset-cancellation phase enable |
| acq_en | output | 1 | Acquisition phase enable |
| conv_en | output | 1 | Bit-decision phase enable |
| sample_stb | output | 1 | One-clock pulse at the sampling instant |
| trial | output | 12 | One-hot trial bit strobe |
| dac_code | output | 12 | Candidate code for the comparator |
| result | output | 12 | Last result, two's complement |
| data_valid | output | 1 | One-clock pulse when `result` is updated |

## Verification
The assertions assume three things about the inputs. First, `convert` and `div_sel` are synchronous to `clk`. Second, `comp_in` settles from `dac_code` within the same clock, so the decision taken at each divided-period boundary belongs to the trial shown during that period. The bench drives every input on the falling edge and computes `comp_in` combinationally from `dac_code` against a model input level, which keeps it within these assumptions. Third, the assertions take `div_sel` as meaningful only at a start edge. The bench deliberately disturbs both `div_sel` and `convert` in the middle of a cycle, to show that neither change alters the running cycle.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_AZ   = 2'd1,
    PH_ACQ  = 2'd2,
    PH_CONV = 2'd3
  } phase_t;

endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] sel,
  input  logic             run,
  output logic             tick
);

  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] sel_q, sel_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] limit;

  always_comb begin
    limit = PRE_W'((32'd1 << sel_q) - 32'd1);
    tick  = run && (pre_q == limit);
  end

  always_comb begin
    sel_d = sel_q;
    pre_d = pre_q;
    if (load) begin
      sel_d = sel;
      pre_d = '0;
    end else if (run) begin
      pre_d = tick ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      pre_q <= '0;
    end else begin
      sel_q <= sel_d;
      pre_q <= pre_d;
    end
  end

  // Above division by one, two divided ticks never arrive back to back.
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel_q != '0) |=> !tick);

  assert_tick_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

endmodule

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
  import sar_seq_pkg::*;
#(
  parameter int AZ_PER   = 8,
  parameter int ACQ_PER  = 28,
  parameter int CONV_PER = 12,
  parameter int TOTAL    = AZ_PER + ACQ_PER + CONV_PER,
  parameter int CNT_W    = $clog2(TOTAL),
  parameter int IDX_W    = $clog2(CONV_PER)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             convert,
  input  logic             tick,
  output logic             start,
  output logic             busy,
  output logic             last,
  output logic             az_en,
  output logic             acq_en,
  output logic             conv_en,
  output logic             sample_stb,
  output logic [IDX_W-1:0] bit_idx
);

  localparam logic [CNT_W-1:0] AZ_END   = CNT_W'(AZ_PER);
  localparam logic [CNT_W-1:0] ACQ_END  = CNT_W'(AZ_PER + ACQ_PER);
  localparam logic [CNT_W-1:0] SAMP_CNT = CNT_W'(AZ_PER + ACQ_PER - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TOTAL - 1);

  logic             conv_q;
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             samp_q, samp_d;
  phase_t           phase;

  always_comb begin
    start = convert && !conv_q && !busy_q;
    last  = tick && (cnt_q == LAST_CNT);
  end

  always_comb begin
    if (!busy_q)              phase = PH_IDLE;
    else if (cnt_q < AZ_END)  phase = PH_AZ;
    else if (cnt_q < ACQ_END) phase = PH_ACQ;
    else                      phase = PH_CONV;
  end

  always_comb begin
    busy       = busy_q;
    az_en      = (phase == PH_AZ);
    acq_en     = (phase == PH_ACQ);
    conv_en    = (phase == PH_CONV);
    sample_stb = samp_q;
    bit_idx    = IDX_W'(LAST_CNT - cnt_q);
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    samp_d = tick && (cnt_q == SAMP_CNT);
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (tick) begin
      if (cnt_q == LAST_CNT) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      samp_q <= 1'b0;
    end else begin
      conv_q <= convert;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      samp_q <= samp_d;
    end
  end

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && cnt_q == '0));

  assert_one_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({az_en, acq_en, conv_en}) == (busy_q ? 1 : 0));

  assert_edge_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> busy_q);

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(cnt_q));

  assert_sample_in_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    samp_q |-> (busy_q && cnt_q == ACQ_END));

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int RES_W = 12,
  parameter int IDX_W = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             conv_en,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             tick,
  input  logic             last,
  input  logic             comp_in,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             data_valid
);

  logic [RES_W-1:0] sar_q, sar_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             vld_q;

  for (genvar i = 0; i < RES_W; i++) begin : g_bit
    always_comb begin
      trial[i] = conv_en && (bit_idx == IDX_W'(i));
      if (clear)                sar_d[i] = 1'b0;
      else if (tick && trial[i]) sar_d[i] = comp_in;
      else                       sar_d[i] = sar_q[i];
    end
  end

  always_comb begin
    dac_code = sar_q | trial;
    res_d    = last ? {~sar_d[RES_W-1], sar_d[RES_W-2:0]} : res_q;
    result     = res_q;
    data_valid = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sar_q <= sar_d;
      res_q <= res_d;
      vld_q <= last;
    end
  end

  assert_trial_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trial) && (conv_en || trial == '0));

  assert_decision_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && conv_en && !clear) |=>
      ((sar_q & $past(trial)) == ($past(comp_in) ? $past(trial) : '0)));

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(res_q));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int RES_W   = 12,
  parameter int AZ_PER  = 8,
  parameter int ACQ_PER = 28,
  parameter int DIV_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             convert,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             comp_in,
  output logic             busy,
  output logic             az_en,
  output logic             acq_en,
  output logic             conv_en,
  output logic             sample_stb,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             data_valid
);

  localparam int TOTAL = AZ_PER + ACQ_PER + RES_W;
  localparam int CNT_W = $clog2(TOTAL);
  localparam int IDX_W = $clog2(RES_W);

  logic [1:0]       rst_pipe;
  logic             rst_s;
  logic             start;
  logic             tick;
  logic             last;
  logic [IDX_W-1:0] bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_s = rst_pipe[1];

  sar_clk_div #(
    .DIV_W (DIV_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_s),
    .load  (start),
    .sel   (div_sel),
    .run   (busy),
    .tick  (tick)
  );

  sar_phase_ctrl #(
    .AZ_PER   (AZ_PER),
    .ACQ_PER  (ACQ_PER),
    .CONV_PER (RES_W),
    .TOTAL    (TOTAL),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s),
    .convert    (convert),
    .tick       (tick),
    .start      (start),
    .busy       (busy),
    .last       (last),
    .az_en      (az_en),
    .acq_en     (acq_en),
    .conv_en    (conv_en),
    .sample_stb (sample_stb),
    .bit_idx    (bit_idx)
  );

  sar_bit_engine #(
    .RES_W (RES_W),
    .IDX_W (IDX_W)
  ) u_sar (
    .clk        (clk),
    .rst_n      (rst_s),
    .clear      (start),
    .conv_en    (conv_en),
    .bit_idx    (bit_idx),
    .tick       (tick),
    .last       (last),
    .comp_in    (comp_in),
    .trial      (trial),
    .dac_code   (dac_code),
    .result     (result),
    .data_valid (data_valid)
  );

  assert_valid_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_s)
    data_valid |-> (!busy && $past(busy)));

endmodule

// File: tb/sar_conv_seq_tb.sv
`timescale 1ns/1ps
module sar_conv_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        convert;
  logic [1:0]  div_sel;
  logic        comp_in;
  logic        busy, az_en, acq_en, conv_en, sample_stb, data_valid;
  logic [11:0] trial, dac_code, result;
  logic [11:0] vin;

  int tests;
  int fails;
  bit done;
  bit have_prev;
  logic [11:0] prev_res;

  sar_conv_seq u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .convert    (convert),
    .div_sel    (div_sel),
    .comp_in    (comp_in),
    .busy       (busy),
    .az_en      (az_en),
    .acq_en     (acq_en),
    .conv_en    (conv_en),
    .sample_stb (sample_stb),
    .trial      (trial),
    .dac_code   (dac_code),
    .result     (result),
    .data_valid (data_valid)
  );

  // Comparator model: input level at or above candidate code keeps the bit.
  assign comp_in = (dac_code <= vin);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input int dc, input int v, input bit disturb);
    int d, n, az_c, acq_c, conv_c, stb_at, stb_cnt;
    int trial_err, hold_err, valid_err, phase_err;
    logic [11:0] et;
    d = 1 << dc;
    vin = 12'(v);
    div_sel = 2'(dc);
    az_c = 0; acq_c = 0; conv_c = 0; stb_at = -1; stb_cnt = 0;
    trial_err = 0; hold_err = 0; valid_err = 0; phase_err = 0;
    @(negedge clk);
    convert = 1'b1;
    @(negedge clk);
    check(busy === 1'b1, "R1 busy after start edge", int'(busy), 1);
    n = 0;
    while (busy === 1'b1 && n < 500) begin
      if (az_en) az_c++;
      if (acq_en) acq_c++;
      if (conv_en) conv_c++;
      if ($countones({az_en, acq_en, conv_en}) != 1) phase_err++;
      if (az_en !== (n < 8*d) || conv_en !== (n >= 36*d)) phase_err++;
      if (sample_stb) begin stb_cnt++; stb_at = n; end
      et = '0;
      if (n >= 36*d) et = 12'h800 >> ((n - 36*d) / d);
      if (trial !== et) trial_err++;
      if (dac_code !== ((dac_code & ~trial) | et)) trial_err++;
      if (data_valid !== 1'b0) valid_err++;
      if (have_prev && result !== prev_res) hold_err++;
      if (disturb && n == 5) begin convert = 1'b0; div_sel = ~2'(dc); end
      if (disturb && n == 6) convert = 1'b1;
      @(negedge clk);
      n++;
    end
    check(n == 48*d, disturb ? "R3/R8 busy length with mid-cycle disturbance" : "R2 busy length", n, 48*d);
    check(az_c == 8*d && acq_c == 28*d && conv_c == 12*d && phase_err == 0,
          "R4 phase durations", az_c*10000 + acq_c*100 + conv_c, 8*d*10000 + 28*d*100 + 12*d);
    check(stb_cnt == 1 && stb_at == 36*d, "R5 sample strobe position", stb_at, 36*d);
    check(trial_err == 0, "R6 trial sequence", trial_err, 0);
    check(valid_err == 0 && hold_err == 0, "R9 result held while busy", hold_err + valid_err, 0);
    check(data_valid === 1'b1, "R9 valid after busy falls", int'(data_valid), 1);
    check(result === (12'(v) ^ 12'h800), "R7 two's complement result", int'(result), int'(12'(v) ^ 12'h800));
    @(negedge clk);
    check(data_valid === 1'b0, "R9 valid lasts one clock", int'(data_valid), 0);
    @(negedge clk);
    @(negedge clk);
    check(busy === 1'b0, "R8 held convert does not retrigger", int'(busy), 0);
    convert = 1'b0;
    prev_res = 12'(v) ^ 12'h800;
    have_prev = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; done = 1'b0; have_prev = 1'b0; prev_res = '0;
    rst_n = 1'b0; convert = 1'b0; div_sel = 2'd0; vin = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy === 1'b0 && az_en === 1'b0 && acq_en === 1'b0 && conv_en === 1'b0,
          "R10 control outputs in reset", int'({busy, az_en, acq_en, conv_en}), 0);
    check(sample_stb === 1'b0 && data_valid === 1'b0 && trial === '0 && result === '0,
          "R10 data outputs in reset", int'(result), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 1'b0, "R10 idle after reset release", int'(busy), 0);

    // R7 corner codes at division by one
    run_conv(0, 0, 1'b0);
    run_conv(0, 4095, 1'b0);
    run_conv(0, 2048, 1'b0);
    run_conv(0, 2047, 1'b0);
    run_conv(0, 1, 1'b0);
    run_conv(0, 2730, 1'b0);
    run_conv(0, 1365, 1'b0);
    // R7 sweep of input levels
    for (int v = 3; v < 4096; v += 41) run_conv(0, v, 1'b0);
    // R3 every divide code, with and without disturbance (R8)
    for (int dc = 1; dc < 4; dc++) begin
      run_conv(dc, 0, 1'b0);
      run_conv(dc, 4095, 1'b0);
      run_conv(dc, 1234, 1'b1);
      run_conv(dc, 3000, 1'b0);
    end
    run_conv(0, 77, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule